// File: doc/BRIEF.md
# WLAN Block Interleaver Address Generator

This block produces the address pair that drives a one-symbol interleaving memory for an OFDM wireless LAN transmitter. Each cycle of an active symbol it emits one write address and one read address. A bit arriving as the k-th coded bit of the symbol is stored at the write address. Reading the memory at the read addresses in order then yields the fully interleaved bit stream. The write side carries the row/column transposition. The read side carries the inverse of the in-group bit swap and the per-stream frequency rotation. Every sequence is stepped by counters, compare-and-wrap logic and small adders. No divider or multiplier runs during operation.

A one-cycle start pulse samples the configuration: modulation, channel width and spatial stream. The addresses for the new symbol follow on the next cycles. A last flag marks the final address pair. A start pulse raised together with the last flag chains the next symbol with no idle cycle. The memory, the data path and the transmit/receive mode control sit outside this block.

Top module: `wlan_intlv_agu`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `addr_valid_o` and `last_o` are 0 and both addresses are 0.
- R2: For symbol index k, `wr_addr_o` = Nrow*(k mod Ncol) + floor(k/Ncol). Ncol is 13 (`bw40_i`=0) or 18 (`bw40_i`=1). Nrow is 4*Nb or 6*Nb respectively. Nb is 1, 2, 4 or 6 bits per subcarrier for `mod_i` codes 0, 1, 2 and 3.
- R3: For index m, `rd_addr_o` is the write address i whose bit leaves at output position m. Here j = s*floor(i/s) + (i + N - floor(i/Nrow)) mod s with s = max(Nb/2,1), and m = (j - J*Nrot*Nb) mod N. N = Ncol*Nrow. Nrot is 11 at 20 MHz and 29 at 40 MHz. J is 0, 2, 1 or 3 for `stream_i` codes 0, 1, 2 and 3.
- R4: With `stream_i`=0 no rotation is applied (J=0) for every modulation and width.
- R5: `last_o` is 1 exactly on the cycle showing index N-1, and only while `addr_valid_o` is 1.
- R6: A start pulse sampled at a clock edge makes the next cycle show index 0. This includes a start raised while `last_o` is 1, which gives back-to-back symbols with no gap.
- R7: `mod_i`, `bw40_i` and `stream_i` are used only at a start pulse. Changing them during a symbol does not alter its addresses.
- R8: A start pulse in the middle of a symbol abandons it, and index 0 of the new configuration follows on the next cycle.
- R9: After the cycle with `last_o`=1, if no start was given, `addr_valid_o` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a symbol; samples the configuration |
| mod_i | input | 2 | Modulation code: 0 BPSK, 1 QPSK, 2 16QAM, 3 64QAM |
| bw40_i | input | 1 | 0 = 20 MHz, 1 = 40 MHz channel |
| stream_i | input | 2 | Spatial stream code 0..3 for streams 1..4 |
| addr_valid_o | output | 1 | Address pair is valid this cycle |
| wr_addr_o | output | 10 | Memory write address for the current index |
| rd_addr_o | output | 10 | Memory read address for the current index |
| last_o | output | 1 | Final address pair of the symbol |

## Verification
Each output register is loaded at the edge that samples `start_i`. Index 0 is therefore due one cycle after the start pulse, and index k is due k+1 cycles after it. `last_o` is due with index N-1, and `addr_valid_o` falls one cycle after that when no start follows. The bench advances its reference index at the same edge as the design, from the same inputs. It compares all four outputs half a cycle later, when they are settled. Both the back-to-back chaining and the mid-symbol restart are covered by that one-cycle start latency.

// File: rtl/intlv_agu_pkg.sv
package intlv_agu_pkg;
  localparam int AW              = 10;
  localparam int COLS_20         = 13;
  localparam int COLS_40         = 18;
  localparam int ROWS_PER_BIT_20 = 4;
  localparam int ROWS_PER_BIT_40 = 6;
  localparam int ROT_20          = 11;
  localparam int ROT_40          = 29;
  localparam int SEL_W           = 5;
  localparam int N_CFG           = 1 << SEL_W;

  typedef struct packed {
    logic [AW-1:0] last_idx;
    logic [AW-1:0] n_row;
    logic [AW-1:0] n_col;
    logic [1:0]    s;
    logic [AW-1:0] gb0;
    logic [AW-1:0] row0;
    logic [AW-1:0] col0;
    logic [1:0]    jg0;
    logic [1:0]    colm0;
  } cfg_t;

  function automatic int bits_per_sc(int code);
    case (code)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  // Elaboration-time only: evaluated with constant arguments to build a ROM.
  function automatic cfg_t cfg_calc(int idx);
    cfg_t c;
    int bw, md, st, nb, ncol, nrow, n, s, jr, rot, off;
    bw   = (idx >> 4) & 1;
    md   = (idx >> 2) & 3;
    st   = idx & 3;
    nb   = bits_per_sc(md);
    ncol = bw ? COLS_40 : COLS_20;
    nrow = (bw ? ROWS_PER_BIT_40 : ROWS_PER_BIT_20) * nb;
    rot  = bw ? ROT_40 : ROT_20;
    n    = ncol * nrow;
    s    = (nb / 2 > 1) ? nb / 2 : 1;
    jr   = ((st * 2) % 3) + 3 * (st / 3);
    off  = (jr * rot * nb) % n;
    c.last_idx = AW'(n - 1);
    c.n_row    = AW'(nrow);
    c.n_col    = AW'(ncol);
    c.s        = 2'(s);
    c.jg0      = 2'(off % s);
    c.gb0      = AW'(off - off % s);
    c.row0     = AW'(off % nrow);
    c.col0     = AW'(off / nrow);
    c.colm0    = 2'((off / nrow) % s);
    return c;
  endfunction
endpackage

// File: rtl/intlv_cfg_rom.sv
module intlv_cfg_rom
  import intlv_agu_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output cfg_t             cfg_o
);
  cfg_t tbl [N_CFG];

  for (genvar g = 0; g < N_CFG; g++) begin : g_entry
    assign tbl[g] = cfg_calc(g);
  end

  assign cfg_o = tbl[sel_i];
endmodule

// File: rtl/intlv_wr_gen.sv
module intlv_wr_gen
  import intlv_agu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  cfg_t          cfg_i,
  output logic [AW-1:0] wr_addr_o
);
  logic [AW-1:0] colw, roww, acc;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      colw <= '0;
      roww <= '0;
      acc  <= '0;
    end else if (step_i) begin
      if (colw == cfg_i.n_col - AW'(1)) begin
        colw <= '0;
        roww <= roww + AW'(1);
        acc  <= roww + AW'(1);
      end else begin
        colw <= colw + AW'(1);
        acc  <= acc + cfg_i.n_row;
      end
    end
  end

  assign wr_addr_o = acc;

  p_wr_range_r2: assert property (@(posedge clk) disable iff (rst)
    acc <= cfg_i.last_idx);
  p_col_range_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.n_col != '0) |-> (colw < cfg_i.n_col));
endmodule

// File: rtl/intlv_rd_gen.sv
module intlv_rd_gen
  import intlv_agu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  cfg_t          ld_cfg_i,
  input  cfg_t          cur_cfg_i,
  output logic [AW-1:0] rd_addr_o
);
  logic [AW-1:0] gb, rowc, col, gb_n, row_n, col_n, rd_n, rd_q;
  logic [1:0]    jg, colm, jg_n, cm_n, s_sel;
  logic [2:0]    q;

  always_comb begin
    gb_n  = gb;
    jg_n  = jg;
    row_n = rowc;
    col_n = col;
    cm_n  = colm;
    s_sel = cur_cfg_i.s;
    if (load_i) begin
      s_sel = ld_cfg_i.s;
      gb_n  = ld_cfg_i.gb0;
      jg_n  = ld_cfg_i.jg0;
      row_n = ld_cfg_i.row0;
      col_n = ld_cfg_i.col0;
      cm_n  = ld_cfg_i.colm0;
    end else if (step_i) begin
      if (col == cur_cfg_i.n_col - AW'(1) && rowc == cur_cfg_i.n_row - AW'(1)) begin
        gb_n  = '0;
        jg_n  = '0;
        row_n = '0;
        col_n = '0;
        cm_n  = '0;
      end else begin
        if (rowc == cur_cfg_i.n_row - AW'(1)) begin
          row_n = '0;
          col_n = col + AW'(1);
          cm_n  = (colm == cur_cfg_i.s - 2'd1) ? 2'd0 : colm + 2'd1;
        end else begin
          row_n = rowc + AW'(1);
        end
        if (jg == cur_cfg_i.s - 2'd1) begin
          jg_n = '0;
          gb_n = gb + AW'(cur_cfg_i.s);
        end else begin
          jg_n = jg + 2'd1;
        end
      end
    end
    q = {1'b0, jg_n} + {1'b0, cm_n};
    if (q >= {1'b0, s_sel}) q = q - {1'b0, s_sel};
    rd_n = gb_n + AW'(q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gb   <= '0;
      jg   <= '0;
      rowc <= '0;
      col  <= '0;
      colm <= '0;
      rd_q <= '0;
    end else begin
      gb   <= gb_n;
      jg   <= jg_n;
      rowc <= row_n;
      col  <= col_n;
      colm <= cm_n;
      rd_q <= rd_n;
    end
  end

  assign rd_addr_o = rd_q;

  p_rd_range_r3: assert property (@(posedge clk) disable iff (rst)
    rd_q <= cur_cfg_i.last_idx);
  p_grp_pos_r3: assert property (@(posedge clk) disable iff (rst)
    (cur_cfg_i.s != 2'd0) |-> (jg < cur_cfg_i.s && colm < cur_cfg_i.s));
endmodule

// File: rtl/wlan_intlv_agu.sv
module wlan_intlv_agu
  import intlv_agu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    mod_i,
  input  logic          bw40_i,
  input  logic [1:0]    stream_i,
  output logic          addr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          last_o
);
  cfg_t          new_cfg, cur_cfg;
  logic [AW-1:0] cnt;
  logic          valid_q, last_q, step;

  intlv_cfg_rom u_rom (
    .sel_i ({bw40_i, mod_i, stream_i}),
    .cfg_o (new_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      cnt     <= '0;
      cur_cfg <= '0;
    end else if (start_i) begin
      cur_cfg <= new_cfg;
      valid_q <= 1'b1;
      cnt     <= new_cfg.last_idx;
      last_q  <= (new_cfg.last_idx == '0);
    end else if (valid_q && !last_q) begin
      cnt    <= cnt - AW'(1);
      last_q <= (cnt == AW'(1));
    end else begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end
  end

  assign step = valid_q && !last_q && !start_i;

  intlv_wr_gen u_wr (
    .clk       (clk),
    .rst       (rst),
    .load_i    (start_i),
    .step_i    (step),
    .cfg_i     (cur_cfg),
    .wr_addr_o (wr_addr_o)
  );

  intlv_rd_gen u_rd (
    .clk       (clk),
    .rst       (rst),
    .load_i    (start_i),
    .step_i    (step),
    .ld_cfg_i  (new_cfg),
    .cur_cfg_i (cur_cfg),
    .rd_addr_o (rd_addr_o)
  );

  assign addr_valid_o = valid_q;
  assign last_o       = last_q;

  p_rst_idle_r1: assert property (@(posedge clk)
    rst |=> (!addr_valid_o && !last_o));
  p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
    last_o |-> addr_valid_o);
  p_start_first_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (addr_valid_o && wr_addr_o == '0));
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(cur_cfg));
  p_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !addr_valid_o);
endmodule

// File: tb/wlan_intlv_agu_tb_top.sv
module wlan_intlv_agu_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] mod_i = 2'd0;
  logic       bw40_i = 1'b0;
  logic [1:0] stream_i = 2'd0;
  logic       addr_valid_o, last_o;
  logic [9:0] wr_addr_o, rd_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R1";

  // reference state
  bit m_valid = 0;
  int m_idx = 0;
  int m_mod = 0, m_bw = 0, m_st = 0;

  always #2.5 clk = ~clk;

  wlan_intlv_agu dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mod_i(mod_i), .bw40_i(bw40_i),
    .stream_i(stream_i), .addr_valid_o(addr_valid_o), .wr_addr_o(wr_addr_o),
    .rd_addr_o(rd_addr_o), .last_o(last_o)
  );

  function automatic int nbits(int md);
    return (md == 0) ? 1 : (md == 1) ? 2 : (md == 2) ? 4 : 6;
  endfunction
  function automatic int ncols(int bw); return bw ? 18 : 13; endfunction
  function automatic int nrows(int bw, int md); return (bw ? 6 : 4) * nbits(md); endfunction
  function automatic int nsym(int bw, int md); return ncols(bw) * nrows(bw, md); endfunction

  function automatic int perm1(int k, int bw, int md);
    return nrows(bw, md) * (k % ncols(bw)) + k / ncols(bw);
  endfunction

  function automatic int outpos(int k, int bw, int md, int st);
    int n, s, i, j, jr, rot, sh;
    n   = nsym(bw, md);
    s   = (nbits(md) / 2 > 1) ? nbits(md) / 2 : 1;
    i   = perm1(k, bw, md);
    j   = s * (i / s) + (i + n - (ncols(bw) * i) / n) % s;
    jr  = (st == 0) ? 0 : (st == 1) ? 2 : (st == 2) ? 1 : 3;
    rot = bw ? 29 : 11;
    sh  = (jr * rot * nbits(md)) % n;
    return (j - sh + n) % n;
  endfunction

  function automatic int exp_rd(int m, int bw, int md, int st);
    for (int k = 0; k < nsym(bw, md); k++)
      if (outpos(k, bw, md, st) == m) return perm1(k, bw, md);
    return -1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d (cfg bw=%0d mod=%0d st=%0d idx=%0d)",
               req, phase, act, exp, m_bw, m_mod, m_st, m_idx);
    end
  endtask

  task automatic compare();
    if (m_valid) begin
      chk("R6_valid", addr_valid_o, 1);
      chk("R2_wr", wr_addr_o, perm1(m_idx, m_bw, m_mod));
      chk(m_st == 0 ? "R4_rd" : "R3_rd", rd_addr_o, exp_rd(m_idx, m_bw, m_mod, m_st));
      chk("R5_last", last_o, (m_idx == nsym(m_bw, m_mod) - 1) ? 1 : 0);
    end else begin
      chk("R9_valid", addr_valid_o, 0);
      chk("R5_last", last_o, 0);
    end
  endtask

  // drive at negedge, model update at posedge, compare at next negedge
  task automatic cycle(bit st_p, int md, int bw, int sn);
    start_i  = st_p;
    mod_i    = 2'(md);
    bw40_i   = bw[0];
    stream_i = 2'(sn);
    @(posedge clk);
    if (rst) m_valid = 0;
    else if (st_p) begin
      m_valid = 1; m_idx = 0; m_mod = md; m_bw = bw; m_st = sn;
    end else if (m_valid) begin
      if (m_idx == nsym(m_bw, m_mod) - 1) m_valid = 0;
      else m_idx++;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int blk_n;
    @(negedge clk);
    // R1: reset state
    cycle(0, 0, 0, 0);
    chk("R1_wr", wr_addr_o, 0);
    chk("R1_rd", rd_addr_o, 0);
    cycle(0, 0, 0, 0);
    rst = 1'b0;
    cycle(0, 0, 0, 0);
    chk("R1_wr", wr_addr_o, 0);

    // R6/R7: all 32 configurations back-to-back, inputs scrambled mid-symbol
    phase = "R6_R7_chain";
    for (int c = 0; c < 32; c++) begin
      int bw = (c >> 4) & 1, md = (c >> 2) & 3, sn = c & 3;
      cycle(1, md, bw, sn);
      blk_n = nsym(bw, md);
      for (int t = 1; t < blk_n; t++) cycle(0, (md + t) & 3, (bw + t) & 1, (sn + 3 * t) & 3);
    end
    phase = "R9_idle";
    cycle(0, 1, 1, 2);
    cycle(0, 3, 0, 1);

    // R8: restart mid-symbol with another configuration
    phase = "R8_restart";
    cycle(1, 3, 1, 3);
    for (int t = 0; t < 20; t++) cycle(0, 0, 0, 0);
    cycle(1, 2, 0, 1);
    for (int t = 1; t < nsym(0, 2); t++) cycle(0, 1, 1, 3);
    phase = "R9_idle";
    for (int t = 0; t < 3; t++) cycle(0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule